// File: doc/BRIEF.md
# Symbol-Rate Output Multiplexer with Aligned Reference Strobe

This block drives a narrow, registered output bus at symbol rate. The bus carries a complex symbol as an in-phase nibble and a quadrature nibble. Each symbol it takes the primary despread symbol. It can also share the symbol period between that primary symbol and one of four auxiliary quantities. The auxiliary quantities are a conventional correlator symbol, an estimated carrier phase, an internal gain level and the modulus of an adaptive vector. The block only selects among these sources. It does not compute them.

Two pulse inputs set the timing. The symbol-start pulse marks the beginning of a symbol. The half-symbol pulse marks its midpoint. Both pass through the same short register chain before they act, which keeps long input paths away from the output flops. A reference pulse leaves the block on the same edge as each symbol load, so downstream logic can frame the bus. Two configuration fields set the behaviour: a swap flag and a 2-bit source selector. They are captured only on the symbol load, so a symbol is never split by a change in configuration.

Top module: `sym_out_mux`

## Requirements
- R1: While `rst` is high at a rising edge, `out_i`, `out_q` and `sym_ref_out` are zero after that edge.
- R2: A pulse on `sym_start_in` sampled at edge k makes `sym_ref_out` high for the one cycle that follows edge k+SYNC_STAGES (default 2), and low otherwise.
- R3: On the edge where `sym_ref_out` rises, the bus is loaded with the primary symbol: `out_i` = `prim_i`, `out_q` = `prim_q`.
- R4: With the captured swap flag at 0, the bus holds the primary symbol for the whole symbol period, and half-symbol pulses have no effect on it.
- R5: With the captured swap flag at 1, a half-symbol pulse (delayed by the same SYNC_STAGES chain) reloads the bus with the selected auxiliary word, which is then held until the next symbol load.
- R6: Source code 00 puts `corr_i` on `out_i` and `corr_q` on `out_q`. Codes 01, 10 and 11 select `carrier_phase`, `gain_level` and `vec_modulus`. For these the upper nibble (bit 7 down to 4) goes to `out_i` and the lower nibble goes to `out_q`. `out_i[3]` is the MSB of the bus and `out_q[0]` is the LSB.
- R7: `swap_sel` and `out_sel` are captured only on a symbol load. A change at any other time leaves the current symbol's output unchanged.
- R8: If the delayed symbol and half-symbol pulses coincide, the symbol load wins and the bus takes the primary symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_start_in | input | 1 | Symbol-start pulse |
| half_start_in | input | 1 | Mid-symbol pulse |
| swap_sel | input | 1 | 1 = share symbol between primary and auxiliary |
| out_sel | input | 2 | Auxiliary source code |
| prim_i | input | NIB_W | Primary symbol, in-phase |
| prim_q | input | NIB_W | Primary symbol, quadrature |
| corr_i | input | NIB_W | Correlator symbol, in-phase |
| corr_q | input | NIB_W | Correlator symbol, quadrature |
| carrier_phase | input | 2*NIB_W | Estimated carrier phase |
| gain_level | input | 2*NIB_W | Internal gain level |
| vec_modulus | input | 2*NIB_W | Adaptive vector modulus |
| out_i | output | NIB_W | Output bus, upper nibble |
| out_q | output | NIB_W | Output bus, lower nibble |
| sym_ref_out | output | 1 | Symbol reference, aligned with the bus load |

## Verification
The assertions check several things on every cycle. The reference pulse only follows a delayed symbol pulse, and a symbol load always takes the primary word. The bus cannot move between loads while swapping is off, and the captured configuration cannot change away from a symbol load. Other behaviours only show up in the bench scenarios. These are the exact latency from the external pulse, the correct auxiliary word for each source code, the nibble placement, and that a configuration change in mid-symbol takes effect only on the following symbol. Those scenarios are compared cycle by cycle against a behavioural model.

// File: rtl/sym_out_mux_pkg.sv
package sym_out_mux_pkg;

  typedef enum logic [1:0] {
    SRC_CORR  = 2'b00,
    SRC_PHASE = 2'b01,
    SRC_GAIN  = 2'b10,
    SRC_MOD   = 2'b11
  } aux_src_e;

  localparam int STB_SYM  = 0;
  localparam int STB_HALF = 1;
  localparam int STB_NUM  = 2;

endpackage

// File: rtl/strobe_delay.sv
module strobe_delay #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] stb_in,
  output logic [WIDTH-1:0] stb_out
);

  generate
    if (STAGES == 0) begin : g_pass
      assign stb_out = stb_in;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage_q[s] <= '0;
          end else if (s == 0) begin
            stage_q[s] <= stb_in;
          end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign stb_out = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/aux_source_select.sv
module aux_source_select
  import sym_out_mux_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  aux_src_e             src,
  input  logic [NIB_W-1:0]     corr_i,
  input  logic [NIB_W-1:0]     corr_q,
  input  logic [2*NIB_W-1:0]   carrier_phase,
  input  logic [2*NIB_W-1:0]   gain_level,
  input  logic [2*NIB_W-1:0]   vec_modulus,
  output logic [NIB_W-1:0]     aux_i,
  output logic [NIB_W-1:0]     aux_q
);

  localparam int WORD_W = 2*NIB_W;

  logic [WORD_W-1:0] word;

  always_comb begin
    unique case (src)
      SRC_CORR:  word = {corr_i, corr_q};
      SRC_PHASE: word = carrier_phase;
      SRC_GAIN:  word = gain_level;
      SRC_MOD:   word = vec_modulus;
      default:   word = '0;
    endcase
  end

  assign aux_i = word[WORD_W-1:NIB_W];
  assign aux_q = word[NIB_W-1:0];

endmodule

// File: rtl/sym_out_register.sv
module sym_out_register
  import sym_out_mux_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_stb,
  input  logic             half_stb,
  input  logic             swap_cfg,
  input  logic [1:0]       src_cfg,
  input  logic [NIB_W-1:0] prim_i,
  input  logic [NIB_W-1:0] prim_q,
  input  logic [NIB_W-1:0] aux_i,
  input  logic [NIB_W-1:0] aux_q,
  output aux_src_e         src_q,
  output logic [NIB_W-1:0] out_i,
  output logic [NIB_W-1:0] out_q,
  output logic             ref_q
);

  logic swap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      swap_q <= 1'b0;
      src_q  <= SRC_CORR;
    end else if (sym_stb) begin
      swap_q <= swap_cfg;
      src_q  <= aux_src_e'(src_cfg);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_i <= '0;
      out_q <= '0;
      ref_q <= 1'b0;
    end else begin
      ref_q <= sym_stb;
      if (sym_stb) begin
        out_i <= prim_i;
        out_q <= prim_q;
      end else if (half_stb && swap_q) begin
        out_i <= aux_i;
        out_q <= aux_q;
      end
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (out_i == '0 && out_q == '0 && !ref_q)); // R1

  AST_SYM_LOAD: assert property (@(posedge clk) disable iff (rst)
    sym_stb |=> ({out_i, out_q} == $past({prim_i, prim_q}) && ref_q)); // R3

  AST_HOLD_NOSWAP: assert property (@(posedge clk) disable iff (rst)
    (!sym_stb && !swap_q) |=> $stable({out_i, out_q})); // R4

  AST_HALF_AUX: assert property (@(posedge clk) disable iff (rst)
    (half_stb && !sym_stb && swap_q) |=> ({out_i, out_q} == $past({aux_i, aux_q}))); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sym_stb |=> ($stable(swap_q) && $stable(src_q))); // R7

endmodule

// File: rtl/sym_out_mux.sv
module sym_out_mux
  import sym_out_mux_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sym_start_in,
  input  logic               half_start_in,
  input  logic               swap_sel,
  input  logic [1:0]         out_sel,
  input  logic [NIB_W-1:0]   prim_i,
  input  logic [NIB_W-1:0]   prim_q,
  input  logic [NIB_W-1:0]   corr_i,
  input  logic [NIB_W-1:0]   corr_q,
  input  logic [2*NIB_W-1:0] carrier_phase,
  input  logic [2*NIB_W-1:0] gain_level,
  input  logic [2*NIB_W-1:0] vec_modulus,
  output logic [NIB_W-1:0]   out_i,
  output logic [NIB_W-1:0]   out_q,
  output logic               sym_ref_out
);

  logic [STB_NUM-1:0] stb_raw;
  logic [STB_NUM-1:0] stb_int;
  aux_src_e           src_cur;
  logic [NIB_W-1:0]   aux_i;
  logic [NIB_W-1:0]   aux_q;

  assign stb_raw[STB_SYM]  = sym_start_in;
  assign stb_raw[STB_HALF] = half_start_in;

  strobe_delay #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (STB_NUM)
  ) i_strobe_delay (
    .clk     (clk),
    .rst     (rst),
    .stb_in  (stb_raw),
    .stb_out (stb_int)
  );

  aux_source_select #(
    .NIB_W (NIB_W)
  ) i_aux_source_select (
    .src           (src_cur),
    .corr_i        (corr_i),
    .corr_q        (corr_q),
    .carrier_phase (carrier_phase),
    .gain_level    (gain_level),
    .vec_modulus   (vec_modulus),
    .aux_i         (aux_i),
    .aux_q         (aux_q)
  );

  sym_out_register #(
    .NIB_W (NIB_W)
  ) i_sym_out_register (
    .clk      (clk),
    .rst      (rst),
    .sym_stb  (stb_int[STB_SYM]),
    .half_stb (stb_int[STB_HALF]),
    .swap_cfg (swap_sel),
    .src_cfg  (out_sel),
    .prim_i   (prim_i),
    .prim_q   (prim_q),
    .aux_i    (aux_i),
    .aux_q    (aux_q),
    .src_q    (src_cur),
    .out_i    (out_i),
    .out_q    (out_q),
    .ref_q    (sym_ref_out)
  );

  AST_REF_ALIGN: assert property (@(posedge clk) disable iff (rst)
    sym_ref_out |-> $past(stb_int[STB_SYM])); // R2

endmodule

// File: tb/test_sym_out_mux.sv
module test_sym_out_mux;

  localparam int  NIB_W = 4;
  localparam int  SYNC  = 2;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_start_in = 1'b0, half_start_in = 1'b0, swap_sel = 1'b0;
  logic [1:0] out_sel = 2'b00;
  logic [3:0] prim_i = '0, prim_q = '0, corr_i = '0, corr_q = '0;
  logic [7:0] carrier_phase = '0, gain_level = '0, vec_modulus = '0;
  logic [3:0] out_i, out_q;
  logic       sym_ref_out;

  int n_vec = 0;
  int n_bad = 0;
  bit model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_out_mux #(.NIB_W(NIB_W), .SYNC_STAGES(SYNC)) i_sym_out_mux (
    .clk(clk), .rst(rst), .sym_start_in(sym_start_in), .half_start_in(half_start_in),
    .swap_sel(swap_sel), .out_sel(out_sel), .prim_i(prim_i), .prim_q(prim_q),
    .corr_i(corr_i), .corr_q(corr_q), .carrier_phase(carrier_phase),
    .gain_level(gain_level), .vec_modulus(vec_modulus),
    .out_i(out_i), .out_q(out_q), .sym_ref_out(sym_ref_out));

  function automatic logic [7:0] aux_word(input logic [1:0] sel);
    case (sel)
      2'd0:    return {corr_i, corr_q};
      2'd1:    return carrier_phase;
      2'd2:    return gain_level;
      default: return vec_modulus;
    endcase
  endfunction

  // behavioural reference model
  bit         sq[$];
  bit         hq[$];
  logic [7:0] m_bus = '0;
  bit         m_ref = 1'b0, m_swap = 1'b0;
  logic [1:0] m_sel = '0;

  initial begin
    for (int k = 0; k < SYNC; k++) begin sq.push_back(1'b0); hq.push_back(1'b0); end
  end

  always @(posedge clk) begin
    bit s_now, h_now;
    s_now = sq.pop_front();
    h_now = hq.pop_front();
    sq.push_back(rst ? 1'b0 : sym_start_in);
    hq.push_back(rst ? 1'b0 : half_start_in);
    if (rst) begin
      for (int k = 0; k < SYNC; k++) begin sq[k] = 1'b0; hq[k] = 1'b0; end
      m_bus = '0; m_ref = 1'b0; m_swap = 1'b0; m_sel = '0;
    end else begin
      m_ref = s_now;
      if (s_now) begin
        m_swap = swap_sel; m_sel = out_sel; m_bus = {prim_i, prim_q};
      end else if (h_now && m_swap) begin
        m_bus = aux_word(m_sel);
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      n_vec++;
      if ({out_i, out_q} !== m_bus) begin
        n_bad++;
        $display("FAIL R3/R5/R6 model bus: actual %h expected %h", {out_i, out_q}, m_bus);
      end
      n_vec++;
      if (sym_ref_out !== m_ref) begin
        n_bad++;
        $display("FAIL R2 model ref: actual %0b expected %0b", sym_ref_out, m_ref);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one symbol of LEN cycles; half pulse at index H; config changed at index 4
  task automatic run_symbol(input logic [7:0] prim, input bit swp, input logic [1:0] sel,
                            input bit swp2, input logic [1:0] sel2,
                            input bit half_with_sym, input string req);
    localparam int LEN = 16;
    localparam int H   = 8;
    logic [7:0] aux_exp;
    aux_exp = aux_word(sel);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      if (i == SYNC+1) begin
        chk("R2 ref high", {7'd0, sym_ref_out}, 8'd1);
        chk({req, " primary at load (R3)"}, {out_i, out_q}, prim);
      end
      if (i == SYNC+2) chk("R2 ref single pulse", {7'd0, sym_ref_out}, 8'd0);
      if (i == H+SYNC) chk({req, " primary before half"}, {out_i, out_q}, prim);
      if (i == LEN-1)
        chk({req, " second half"}, {out_i, out_q}, swp ? aux_exp : prim);
      sym_start_in  = (i == 0);
      half_start_in = (i == H) || (half_with_sym && i == 0);
      if (i == 0) begin
        {prim_i, prim_q} = prim; swap_sel = swp; out_sel = sel;
      end
      if (i == 4) begin swap_sel = swp2; out_sel = sel2; end
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    corr_i = 4'hA; corr_q = 4'h5;
    carrier_phase = 8'h3C; gain_level = 8'hE1; vec_modulus = 8'h96;
    prim_i = 4'h7; prim_q = 4'h2;
    repeat (3) @(negedge clk);
    chk("R1 reset bus", {out_i, out_q}, 8'h00);
    chk("R1 reset ref", {7'd0, sym_ref_out}, 8'd0);
    rst = 1'b0;
    model_on = 1'b1;
    // R4: no swap, half pulse ignored
    run_symbol(8'h72, 1'b0, 2'd1, 1'b0, 2'd1, 1'b0, "R4");
    // R5/R6: each source code, upper nibble on out_i
    run_symbol(8'h1F, 1'b1, 2'd0, 1'b1, 2'd0, 1'b0, "R6 src00");
    run_symbol(8'h2E, 1'b1, 2'd1, 1'b1, 2'd1, 1'b0, "R6 src01");
    run_symbol(8'h3D, 1'b1, 2'd2, 1'b1, 2'd2, 1'b0, "R5 src10");
    run_symbol(8'h4C, 1'b1, 2'd3, 1'b1, 2'd3, 1'b0, "R6 src11");
    // R7: mid-symbol config change has no effect on this symbol
    run_symbol(8'h5B, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, "R7 swap change");
    run_symbol(8'h6A, 1'b1, 2'd1, 1'b0, 2'd2, 1'b0, "R7 swap/sel change");
    // R8: coinciding strobes, symbol wins
    run_symbol(8'h89, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1, "R8 coincide");
    // idle tail: last output holds
    repeat (SYNC+2) @(negedge clk);
    sym_start_in = 1'b0; half_start_in = 1'b0;
    chk("R5 hold after symbol", {out_i, out_q}, gain_level);
    // R1: reset mid-operation
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears bus", {out_i, out_q}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    model_on = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule